// File: doc/BRIEF.md
# Programmable Chip Select Unit

This block watches an internal bus and turns each bus cycle into an external chip enable for one of several address windows. It has four channels, and each channel owns a fixed address window picked out by the upper eight address bits. Each channel also has one configuration register. That register decides whether the channel takes part at all, which directions and access kinds it accepts, and how the cycle is ended.

A cycle starts with a one-clock start pulse that carries the address, the direction and the access kind. The lowest-numbered channel that matches captures the cycle and drives its active-low chip enable. It also hands its port size and write-enable setting to the bus controller. If the channel's termination enable is set, the unit counts wait states and then pulses an internal termination signal. The count comes from the read wait-state field on reads and from the write wait-state field on writes. An external acknowledge input can end any cycle at any time. A cycle that no channel matches leaves every output idle.

Configuration words are written one channel at a time through a simple write strobe. The bit layout is given in R3, R4 and R8.

Top module: `chip_select_unit`

## Requirements
- R1: After reset every channel's enable bit (config bit 0) is clear, so all chip enables stay high, internal termination stays low and the attribute outputs read zero. A channel whose enable bit is clear never asserts its chip enable.
- R2: A channel matches only when cycle address bits 31:24 equal its base tag. The default base tags are 8'h40 + channel index. Lower address bits play no part in the match.
- R3: The direction option is config bits 14:13: 01 accepts reads only, 10 accepts writes only, 11 accepts both, 00 accepts none. A cycle in a direction that is not accepted does not match.
- R4: The access option is config bits 16:15: 01 accepts data only, 10 accepts instruction fetches only, 11 accepts both. A cycle of a kind that is not accepted does not match.
- R5: When several channels match, the lowest-numbered one wins. At most one chip enable is low at any time.
- R6: A start pulse that no channel matches asserts no chip enable and produces no termination.
- R7: Internal termination is produced only when both the enable bit and the termination-enable bit (config bit 1) are set. With bit 1 clear, the chip enable stays low until the external acknowledge arrives.
- R8: The read wait count is config bits 5:2 and the write wait count is config bits 9:6. With count N, internal termination is a one-clock pulse that goes high N+1 clock edges after the edge that samples the start pulse.
- R9: The external acknowledge ends an active cycle at the next edge, even when internal termination is enabled and still counting. No internal termination follows.
- R10: The chip enable goes high at the clock edge after the one on which the internal termination pulse is high.
- R11: While a cycle is active, the port size (config bits 11:10) and write enable (config bit 12) of the winning channel appear on the attribute outputs. While idle, these outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Channel whose configuration is written |
| cfg_wdata | input | 17 | Configuration word |
| cyc_start | input | 1 | One-clock pulse that starts a bus cycle |
| cyc_addr | input | 32 | Cycle address |
| cyc_read | input | 1 | 1 = read, 0 = write |
| cyc_insn | input | 1 | 1 = instruction fetch, 0 = data |
| ext_ta | input | 1 | External acknowledge, ends the active cycle |
| cs_n | output | 4 | Active-low chip enable per channel |
| int_ta | output | 1 | Internal termination pulse |
| act_psize | output | 2 | Port size of the active channel |
| act_wr_en | output | 1 | Write enable of the active channel |

## Verification
The priority rule is the hardest case to reach from the ports. With the default base tags, every window is distinct, so two channels can never match the same cycle. The bench therefore builds a second copy of the unit whose three upper channels share one tag. It gives the lowest of them a read-only option, so that a read and a write to the same address must pick different winners. A second hard case is the race between an early external acknowledge and a wait counter that is still running. The bench places that acknowledge a known number of clocks after the start pulse and expects no internal pulse afterwards.

// File: rtl/csu_pkg.sv
package csu_pkg;

    localparam int CSU_NCH  = 4;
    localparam int CSU_AW   = 32;
    localparam int CSU_TAGW = 8;
    localparam int CSU_WSW  = 4;
    localparam int CSU_PSW  = 2;

    typedef enum logic [1:0] {
        DIR_NONE = 2'b00,
        DIR_RD   = 2'b01,
        DIR_WR   = 2'b10,
        DIR_ANY  = 2'b11
    } dir_opt_e;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_DATA = 2'b01,
        ACC_INSN = 2'b10,
        ACC_ANY  = 2'b11
    } acc_opt_e;

    // One channel configuration word, MSB first.
    typedef struct packed {
        acc_opt_e               acc;
        dir_opt_e               dir;
        logic                   wr_en;
        logic [CSU_PSW-1:0]     psize;
        logic [CSU_WSW-1:0]     wws;
        logic [CSU_WSW-1:0]     ws;
        logic                   term_en;
        logic                   en;
    } chan_cfg_t;

    localparam int CSU_CFGW = $bits(chan_cfg_t);

    // Attributes held for the duration of an active cycle.
    typedef struct packed {
        logic                   term_en;
        logic                   wr_en;
        logic [CSU_PSW-1:0]     psize;
    } act_attr_t;

    function automatic logic dir_allows(input dir_opt_e d, input logic is_read);
        return is_read ? d[0] : d[1];
    endfunction

    function automatic logic acc_allows(input acc_opt_e a, input logic is_insn);
        return is_insn ? a[1] : a[0];
    endfunction

    function automatic logic [CSU_WSW-1:0] wait_load(input chan_cfg_t c, input logic is_read);
        return is_read ? c.ws : c.wws;
    endfunction

    function automatic act_attr_t attr_of(input chan_cfg_t c);
        act_attr_t a;
        a.term_en = c.term_en;
        a.wr_en   = c.wr_en;
        a.psize   = c.psize;
        return a;
    endfunction

endpackage

// File: rtl/csu_cfg_regs.sv
module csu_cfg_regs
    import csu_pkg::*;
#(
    parameter int NCH = CSU_NCH,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [IW-1:0]         sel,
    input  chan_cfg_t             wdata,
    output chan_cfg_t [NCH-1:0]   cfg_o
);

    for (genvar i = 0; i < NCH; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_o[i] <= '0;
            end else if (we && sel == IW'(i)) begin
                cfg_o[i] <= wdata;
            end
        end
    end

endmodule

// File: rtl/csu_match.sv
module csu_match
    import csu_pkg::*;
#(
    parameter int NCH  = CSU_NCH,
    parameter int AW   = CSU_AW,
    parameter int TAGW = CSU_TAGW,
    parameter logic [NCH*TAGW-1:0] BASES = 32'h43424140,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  chan_cfg_t [NCH-1:0]   cfg,
    input  logic [AW-1:0]         addr,
    input  logic                  is_read,
    input  logic                  is_insn,
    output logic [NCH-1:0]        hit_vec,
    output logic                  win_any,
    output logic [IW-1:0]         win_idx
);

    localparam logic [AW-1:0] TAG_MASK = {{TAGW{1'b1}}, {(AW-TAGW){1'b0}}};

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        logic [AW-1:0] base_full;
        logic          addr_ok;
        logic          opt_ok;
        assign base_full  = {BASES[i*TAGW +: TAGW], {(AW-TAGW){1'b0}}};
        assign addr_ok    = ((addr ^ base_full) & TAG_MASK) == '0;
        assign opt_ok     = dir_allows(cfg[i].dir, is_read) && acc_allows(cfg[i].acc, is_insn);
        assign hit_vec[i] = cfg[i].en && addr_ok && opt_ok;
    end

    // Fixed priority: the lowest index wins.
    always_comb begin
        win_idx = '0;
        for (int j = NCH - 1; j >= 0; j--) begin
            if (hit_vec[j]) win_idx = IW'(j);
        end
    end

    assign win_any = |hit_vec;

endmodule

// File: rtl/csu_wait_ctrl.sv
module csu_wait_ctrl
    import csu_pkg::*;
#(
    parameter int NCH = CSU_NCH,
    parameter int WSW = CSU_WSW,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            hit_any,
    input  logic [IW-1:0]   hit_idx,
    input  logic [WSW-1:0]  load_cnt,
    input  act_attr_t       hit_attr,
    input  logic            ext_ta,
    output logic            busy_o,
    output logic [IW-1:0]   idx_o,
    output act_attr_t       attr_o,
    output logic            int_ta_o
);

    logic [WSW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            idx_o    <= '0;
            attr_o   <= '0;
            cnt_q    <= '0;
            int_ta_o <= 1'b0;
        end else if (!busy_o) begin
            int_ta_o <= 1'b0;
            if (start && hit_any) begin
                busy_o <= 1'b1;
                idx_o  <= hit_idx;
                attr_o <= hit_attr;
                cnt_q  <= load_cnt;
            end
        end else if (ext_ta || int_ta_o) begin
            busy_o   <= 1'b0;
            int_ta_o <= 1'b0;
        end else begin
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
            int_ta_o <= attr_o.term_en && (cnt_q == '0);
        end
    end

    // R8: the termination pulse lasts exactly one clock
    assert_ta_single_R8: assert property (@(posedge clk) disable iff (rst)
        int_ta_o |=> !int_ta_o);

    // R10: the cycle is released right after the termination pulse
    assert_release_after_ta_R10: assert property (@(posedge clk) disable iff (rst)
        int_ta_o |=> !busy_o);

    // R9: an external acknowledge ends the cycle with no internal pulse after it
    assert_ext_end_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && ext_ta && !int_ta_o) |=> (!busy_o && !int_ta_o));

    // R6: an idle unit stays idle unless a matching start arrives
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !(start && hit_any)) |=> !busy_o);

    // R7: no termination pulse for a cycle captured without termination enable
    assert_no_int_ta_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !attr_o.term_en) |=> !int_ta_o);

endmodule

// File: rtl/chip_select_unit.sv
module chip_select_unit
    import csu_pkg::*;
#(
    parameter int NCH  = CSU_NCH,
    parameter int AW   = CSU_AW,
    parameter int TAGW = CSU_TAGW,
    parameter logic [NCH*TAGW-1:0] BASES = 32'h43424140,
    localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CFGW = CSU_CFGW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IW-1:0]       cfg_sel,
    input  logic [CFGW-1:0]     cfg_wdata,
    input  logic                cyc_start,
    input  logic [AW-1:0]       cyc_addr,
    input  logic                cyc_read,
    input  logic                cyc_insn,
    input  logic                ext_ta,
    output logic [NCH-1:0]      cs_n,
    output logic                int_ta,
    output logic [CSU_PSW-1:0]  act_psize,
    output logic                act_wr_en
);

    chan_cfg_t [NCH-1:0] cfg;
    logic [NCH-1:0]      hit_vec;
    logic                win_any;
    logic [IW-1:0]       win_idx;
    chan_cfg_t           win_cfg;
    logic                busy;
    logic [IW-1:0]       act_idx;
    act_attr_t           act_attr;

    csu_cfg_regs #(.NCH(NCH)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (chan_cfg_t'(cfg_wdata)),
        .cfg_o (cfg)
    );

    csu_match #(.NCH(NCH), .AW(AW), .TAGW(TAGW), .BASES(BASES)) u_match (
        .cfg     (cfg),
        .addr    (cyc_addr),
        .is_read (cyc_read),
        .is_insn (cyc_insn),
        .hit_vec (hit_vec),
        .win_any (win_any),
        .win_idx (win_idx)
    );

    assign win_cfg = cfg[win_idx];

    csu_wait_ctrl #(.NCH(NCH), .WSW(CSU_WSW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .start    (cyc_start),
        .hit_any  (win_any),
        .hit_idx  (win_idx),
        .load_cnt (wait_load(win_cfg, cyc_read)),
        .hit_attr (attr_of(win_cfg)),
        .ext_ta   (ext_ta),
        .busy_o   (busy),
        .idx_o    (act_idx),
        .attr_o   (act_attr),
        .int_ta_o (int_ta)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_cs
        assign cs_n[i] = ~(busy && act_idx == IW'(i) && cfg[i].en);
    end

    assign act_psize = busy ? act_attr.psize : '0;
    assign act_wr_en = busy && act_attr.wr_en;

    // R5: never more than one chip enable low
    assert_single_cs_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R11: attribute outputs rest at zero when no chip enable is low
    assert_idle_attrs_R11: assert property (@(posedge clk) disable iff (rst)
        (&cs_n && !busy) |-> (act_psize == '0 && !act_wr_en));

    // R1: the cycle after reset has every chip enable high
    assert_reset_idle_R1: assert property (@(posedge clk)
        $fell(rst) |-> (&cs_n && !int_ta));

    // R2: a chip enable falls only for a start whose tag matched
    assert_cs_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        (&cs_n && !busy && !(cyc_start && win_any)) |=> &cs_n);

endmodule

// File: tb/chip_select_unit_bench.sv
module chip_select_unit_bench;
    import csu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [16:0] cfg_wdata = '0;
    logic        cyc_start = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_read = 1'b0;
    logic        cyc_insn = 1'b0;
    logic        ext_ta = 1'b0;
    logic [3:0]  cs_n, cs_n_ov;
    logic        int_ta, int_ta_ov;
    logic [1:0]  act_psize, act_psize_ov;
    logic        act_wr_en, act_wr_en_ov;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    chip_select_unit u_chip_select_unit (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_read(cyc_read), .cyc_insn(cyc_insn),
        .ext_ta(ext_ta), .cs_n(cs_n), .int_ta(int_ta), .act_psize(act_psize), .act_wr_en(act_wr_en)
    );

    // Second copy with overlapping windows on channels 1..3 (tag 8'h60).
    chip_select_unit #(.BASES(32'h60606050)) u_chip_select_unit_ovl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_read(cyc_read), .cyc_insn(cyc_insn),
        .ext_ta(ext_ta), .cs_n(cs_n_ov), .int_ta(int_ta_ov), .act_psize(act_psize_ov),
        .act_wr_en(act_wr_en_ov)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(input bit en, input bit te, input int ws, input int wws,
                                       input int ps, input bit we, input int dir, input int acc);
        return {acc[1:0], dir[1:0], we, ps[1:0], wws[3:0], ws[3:0], te, en};
    endfunction

    task automatic wcfg(input int ch, input logic [16:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = ch[1:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one cycle; results counted in negedges after the start is driven.
    task automatic run_cyc(input logic [31:0] a, input bit rd, input bit insn, input int ext_at,
                           output logic [3:0] mask, output logic [3:0] mask_ov,
                           output int ta_at, output int low_cnt,
                           output int ps1, output int we1);
        mask = '0; mask_ov = '0; ta_at = 0; low_cnt = 0; ps1 = 0; we1 = 0;
        @(negedge clk);
        cyc_start = 1'b1; cyc_addr = a; cyc_read = rd; cyc_insn = insn;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            mask    = mask | ~cs_n;
            mask_ov = mask_ov | ~cs_n_ov;
            if (cs_n != 4'hF) low_cnt++;
            if (int_ta && ta_at == 0) ta_at = k;
            if (k == 1) begin ps1 = int'(act_psize); we1 = int'(act_wr_en); end
            cyc_start = 1'b0;
            ext_ta = (k == ext_at);
        end
        ext_ta = 1'b0;
    endtask

    logic [3:0] m, mo;
    int ta, lc, ps, we;

    task automatic t_reset;
        chk(cs_n == 4'hF, "R1", "cs_n after reset", int'(cs_n), 15);
        chk(!int_ta, "R1", "int_ta after reset", int'(int_ta), 0);
        chk(act_psize == 0 && !act_wr_en, "R1", "attrs after reset", int'(act_psize), 0);
        run_cyc(32'h4000_0010, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0 && ta == 0, "R1", "reset-disabled channel response", int'(m), 0);
    endtask

    task automatic t_disabled;
        wcfg(0, mk(0, 1, 0, 0, 1, 1, 3, 3));
        run_cyc(32'h40AB_CDEF, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0, "R1", "enable clear keeps cs high", int'(m), 0);
        chk(ta == 0, "R1", "no termination when disabled", ta, 0);
    endtask

    task automatic t_read_write_wait;
        wcfg(1, mk(1, 1, 3, 7, 2, 1, 3, 3));
        run_cyc(32'h4100_1234, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 4'b0010, "R2", "tag 41 selects channel 1", int'(m), 2);
        chk(ta == 5, "R8", "read wait ws=3 pulse position", ta, 5);
        chk(lc == 5, "R10", "cs low cycles on read", lc, 5);
        chk(ps == 2, "R11", "active port size", ps, 2);
        chk(we == 1, "R11", "active write enable", we, 1);
        chk(act_psize == 0 && !act_wr_en, "R11", "attrs idle after cycle", int'(act_psize), 0);
        run_cyc(32'h41FF_0000, 0, 0, 0, m, mo, ta, lc, ps, we);
        chk(ta == 9, "R8", "write wait wws=7 pulse position", ta, 9);
        chk(lc == 9, "R10", "cs low cycles on write", lc, 9);
        run_cyc(32'h0000_0041, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0, "R2", "low address bits do not match", int'(m), 0);
    endtask

    task automatic t_direction;
        wcfg(2, mk(1, 1, 0, 0, 0, 0, 1, 3));
        run_cyc(32'h4200_0000, 0, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0 && ta == 0, "R3", "write refused by read-only channel", int'(m), 0);
        run_cyc(32'h4200_0000, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 4'b0100, "R3", "read accepted by read-only channel", int'(m), 4);
        chk(ta == 2, "R8", "zero wait pulse position", ta, 2);
    endtask

    task automatic t_access;
        wcfg(3, mk(1, 1, 1, 1, 3, 0, 3, 2));
        run_cyc(32'h4300_0000, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0, "R4", "data refused by fetch-only channel", int'(m), 0);
        run_cyc(32'h4300_0000, 1, 1, 0, m, mo, ta, lc, ps, we);
        chk(m == 4'b1000, "R4", "fetch accepted by fetch-only channel", int'(m), 8);
    endtask

    task automatic t_no_match;
        run_cyc(32'h9900_0000, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(m == 0, "R6", "unmatched cs", int'(m), 0);
        chk(ta == 0, "R6", "unmatched termination", ta, 0);
    endtask

    task automatic t_external;
        wcfg(0, mk(1, 0, 2, 2, 1, 0, 3, 3));
        run_cyc(32'h4000_0000, 1, 0, 6, m, mo, ta, lc, ps, we);
        chk(ta == 0, "R7", "no internal termination when disabled", ta, 0);
        chk(lc == 6, "R7", "cs held until external ack", lc, 6);
        wcfg(0, mk(1, 1, 5, 5, 1, 0, 3, 3));
        run_cyc(32'h4000_0000, 1, 0, 2, m, mo, ta, lc, ps, we);
        chk(lc == 2, "R9", "early external ack ends cycle", lc, 2);
        chk(ta == 0, "R9", "no internal pulse after early ack", ta, 0);
    endtask

    task automatic t_priority;
        wcfg(1, mk(1, 1, 0, 0, 0, 0, 1, 3));
        wcfg(2, mk(1, 1, 0, 0, 0, 0, 3, 3));
        wcfg(3, mk(1, 1, 0, 0, 0, 0, 3, 3));
        run_cyc(32'h6000_0000, 1, 0, 0, m, mo, ta, lc, ps, we);
        chk(mo == 4'b0010, "R5", "read picks lowest matching channel", int'(mo), 2);
        run_cyc(32'h6000_0000, 0, 0, 0, m, mo, ta, lc, ps, we);
        chk(mo == 4'b0100, "R5", "write skips read-only channel", int'(mo), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_read_write_wait();
        t_direction();
        t_access();
        t_no_match();
        t_external();
        t_priority();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule